// File: doc/BRIEF.md
# Bitmap Presence Sorter

This block orders a batch of small unsigned values without ever comparing two of them. It holds one occupancy entry for every value the input width can express, which is 256 entries for 8-bit data. Each accepted input value is used directly as an address, and the entry at that address is marked. When the batch-end strobe arrives, the block sweeps every address from zero upward. It emits an address once for each occurrence recorded at that address, so the output stream comes out in ascending order.

The entry width is a parameter. With a width of one bit, each entry is a presence flag, and repeated values collapse into a single output. With the default width of three bits, each entry counts arrivals up to a ceiling, and the value is repeated on the output that many times. Every emission decrements its entry, so the table is empty again when the sweep ends. This means a new batch needs no separate clearing pass. While the sweep runs, a busy flag is high and the input port is ignored. A one-cycle done pulse marks the end of the sweep.

Top module: `bitmap_sorter`

## Requirements
- R1: After reset, busy, out_valid and out_done are all 0.
- R2: While busy is 0, each cycle with in_valid high records in_data in the entry whose address equals that value.
- R3: A cycle with in_last high and busy low starts a sweep. busy is 1 from the next cycle until the cycle in which out_done is high.
- R4: Within one sweep, the values presented with out_valid never decrease.
- R5: With CNT_W=3, a value received k times is output min(k,7) times. The entry saturates at 7.
- R6: With CNT_W=1, a value received one or more times is output exactly once.
- R7: Every address from 0 to 255 is visited. out_done rises exactly 256 + E cycles after the in_last cycle, where E is the sum of (outputs − 1) over all marked addresses. An empty batch takes 256 cycles.
- R8: out_done is high for exactly one cycle per sweep, and busy is 0 in that cycle.
- R9: in_valid and in_last are ignored while busy is 1. Such values never appear in any later output.
- R10: The sweep leaves every entry cleared, so the next batch outputs only its own values.
- R11: When in_valid and in_last are high in the same cycle, that value belongs to the batch being closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | in_data holds a value for the current batch |
| in_data | input | VAL_W | Value to be sorted |
| in_last | input | 1 | Closes the batch and starts the sweep |
| busy | output | 1 | Sweep in progress; input port ignored |
| out_valid | output | 1 | out_data holds the next sorted value |
| out_data | output | VAL_W | Sorted value |
| out_done | output | 1 | One-cycle pulse after the top address has been drained |

## Verification
The checker watches, on every cycle, the properties that hold regardless of the data:
- output order never decreases within a sweep;
- the done pulse lasts one cycle and coincides with busy falling;
- outputs appear only while sweeping or on the done cycle;
- busy rises only after a batch end;
- at least 256 busy cycles pass before done.

Only the bench scenarios can show the rest:
- exact multiplicities under saturation and in single-bit mode;
- the precise sweep length;
- that input given during a sweep is dropped;
- that the table is empty for the following batch.

// File: rtl/bsort_pkg.sv
package bsort_pkg;

    localparam int DEF_VAL_W = 8;
    localparam int DEF_CNT_W = 3;

    typedef enum logic {
        SC_LOAD = 1'b0,
        SC_SWEEP = 1'b1
    } sc_state_e;

    typedef struct packed {
        logic valid;
        logic done;
    } beat_flags_t;

endpackage

// File: rtl/bsort_table.sv
module bsort_table
    import bsort_pkg::*;
#(
    parameter int VAL_W = DEF_VAL_W,
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [VAL_W-1:0] wr_addr,
    input  logic             rd_dec,
    input  logic [VAL_W-1:0] rd_addr,
    output logic [CNT_W-1:0] rd_cnt
);
    localparam int DEPTH = 1 << VAL_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [DEPTH-1:0][CNT_W-1:0] ent_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [CNT_W-1:0] e_q;
        logic             hit_wr;
        logic             hit_rd;
        assign hit_wr = wr_en && (wr_addr == VAL_W'(i));
        assign hit_rd = rd_dec && (rd_addr == VAL_W'(i));

        if (CNT_W == 1) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst)         e_q <= '0;
                else if (hit_wr) e_q <= 1'b1;
                else if (hit_rd) e_q <= 1'b0;
            end
        end else begin : g_count
            always_ff @(posedge clk) begin
                if (rst) begin
                    e_q <= '0;
                end else if (hit_wr) begin
                    if (e_q != CNT_MAX) e_q <= e_q + CNT_W'(1);
                end else if (hit_rd) begin
                    e_q <= e_q - CNT_W'(1);
                end
            end
        end
        assign ent_q[i] = e_q;
    end

    assign rd_cnt = ent_q[rd_addr];

endmodule

// File: rtl/bsort_sweep.sv
module bsort_sweep
    import bsort_pkg::*;
#(
    parameter int VAL_W = DEF_VAL_W,
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VAL_W-1:0] in_data,
    input  logic             in_last,
    input  logic [CNT_W-1:0] rd_cnt,
    output logic             wr_en,
    output logic [VAL_W-1:0] wr_addr,
    output logic             rd_dec,
    output logic [VAL_W-1:0] rd_addr,
    output logic             busy,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_data,
    output logic             out_done
);
    localparam logic [VAL_W-1:0] TOP_ADDR = '1;

    sc_state_e        state_q;
    logic [VAL_W-1:0] addr_q;
    logic [VAL_W-1:0] data_q;
    beat_flags_t      flags_q;
    logic             in_sweep;
    logic             advance;

    assign in_sweep = (state_q == SC_SWEEP);
    assign wr_en    = (state_q == SC_LOAD) && in_valid;
    assign wr_addr  = in_data;
    assign rd_addr  = addr_q;
    assign rd_dec   = in_sweep && (rd_cnt != '0);
    assign advance  = in_sweep && (rd_cnt <= CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SC_LOAD;
            addr_q  <= '0;
            data_q  <= '0;
            flags_q <= '0;
        end else begin
            flags_q.valid <= rd_dec;
            flags_q.done  <= advance && (addr_q == TOP_ADDR);
            data_q        <= addr_q;
            case (state_q)
                SC_LOAD: begin
                    if (in_last) begin
                        state_q <= SC_SWEEP;
                        addr_q  <= '0;
                    end
                end
                SC_SWEEP: begin
                    if (advance) begin
                        addr_q <= addr_q + VAL_W'(1);
                        if (addr_q == TOP_ADDR) state_q <= SC_LOAD;
                    end
                end
                default: state_q <= SC_LOAD;
            endcase
        end
    end

    assign busy      = in_sweep;
    assign out_valid = flags_q.valid;
    assign out_data  = data_q;
    assign out_done  = flags_q.done;

endmodule

// File: rtl/bitmap_sorter.sv
module bitmap_sorter
    import bsort_pkg::*;
#(
    parameter int VAL_W = DEF_VAL_W,
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VAL_W-1:0] in_data,
    input  logic             in_last,
    output logic             busy,
    output logic             out_valid,
    output logic [VAL_W-1:0] out_data,
    output logic             out_done
);
    logic             wr_en;
    logic [VAL_W-1:0] wr_addr;
    logic             rd_dec;
    logic [VAL_W-1:0] rd_addr;
    logic [CNT_W-1:0] rd_cnt;

    bsort_table #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_table (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .rd_dec  (rd_dec),
        .rd_addr (rd_addr),
        .rd_cnt  (rd_cnt)
    );

    bsort_sweep #(.VAL_W(VAL_W), .CNT_W(CNT_W)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_last   (in_last),
        .rd_cnt    (rd_cnt),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .rd_dec    (rd_dec),
        .rd_addr   (rd_addr),
        .busy      (busy),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_done  (out_done)
    );

endmodule

// File: rtl/bsort_checker.sv
module bsort_checker #(
    parameter int VAL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_last,
    input logic             busy,
    input logic             out_valid,
    input logic [VAL_W-1:0] out_data,
    input logic             out_done
);
    localparam int DEPTH = 1 << VAL_W;

    logic [VAL_W-1:0] prev_q;
    logic             have_q;
    logic [15:0]      busy_cyc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            have_q <= 1'b0;
        end else if (out_done) begin
            have_q <= 1'b0;
        end else if (out_valid) begin
            prev_q <= out_data;
            have_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       busy_cyc_q <= '0;
        else if (busy) busy_cyc_q <= busy_cyc_q + 16'd1;
        else           busy_cyc_q <= '0;
    end

    assert_ascending_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && have_q) |-> (out_data >= prev_q));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> out_done);

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(in_last));

    assert_out_in_sweep_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (busy || out_done));

    assert_full_sweep_R7: assert property (@(posedge clk) disable iff (rst)
        out_done |-> (busy_cyc_q >= 16'(DEPTH)));

endmodule

bind bitmap_sorter bsort_checker #(.VAL_W(VAL_W)) u_bsort_checker (
    .clk       (clk),
    .rst       (rst),
    .in_last   (in_last),
    .busy      (busy),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_done  (out_done)
);

// File: tb/test_bitmap_sorter.sv
module test_bitmap_sorter;

    logic       clk = 1'b0;
    logic       rst;
    logic       in_valid, in_last;
    logic [7:0] in_data;
    logic       busy_c, ov_c, dn_c;
    logic [7:0] od_c;
    logic       busy_s, ov_s, dn_s;
    logic [7:0] od_s;

    int total = 0;
    int bad   = 0;
    int mc [256];
    int ms [256];
    int exp_c[$], exp_s[$], got_c[$], got_s[$];
    int extra;
    int done_c, done_s, pulses_c, pulses_s;

    always #2.5 clk = ~clk;

    bitmap_sorter #(.VAL_W(8), .CNT_W(3)) i_bitmap_sorter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .busy(busy_c), .out_valid(ov_c), .out_data(od_c), .out_done(dn_c));

    bitmap_sorter #(.VAL_W(8), .CNT_W(1)) i_bitmap_sorter_single (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .busy(busy_s), .out_valid(ov_s), .out_data(od_s), .out_done(dn_s));

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic clear_model();
        for (int v = 0; v < 256; v++) begin
            mc[v] = 0;
            ms[v] = 0;
        end
    endtask

    task automatic push_val(input int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(v);
        in_last  = 1'b0;
        if (mc[v] < 7) mc[v]++;
        ms[v] = 1;
    endtask

    task automatic build_exp();
        int marked;
        marked = 0;
        exp_c.delete();
        exp_s.delete();
        for (int v = 0; v < 256; v++) begin
            for (int k = 0; k < mc[v]; k++) exp_c.push_back(v);
            if (ms[v] != 0) begin
                exp_s.push_back(v);
                marked++;
            end
        end
        extra = exp_c.size() - marked;
    endtask

    // closes the batch (optionally with a value), collects both sweeps, compares
    task automatic close_and_check(input string name, input bit with_val, input int v,
                                   input bit inject);
        int lim;
        @(negedge clk);
        in_last  = 1'b1;
        in_valid = with_val;
        in_data  = 8'(v);
        if (with_val) begin
            if (mc[v] < 7) mc[v]++;
            ms[v] = 1;
        end
        build_exp();
        got_c.delete();
        got_s.delete();
        done_c = 0; done_s = 0; pulses_c = 0; pulses_s = 0;
        @(posedge clk);
        #1;
        in_last  = 1'b0;
        in_valid = 1'b0;
        for (int n = 1; n <= 2400; n++) begin
            @(posedge clk);
            #1;
            if (n == 1) check(busy_c == 1'b1, {name, " R3 busy after batch end"}, busy_c, 1);
            if (ov_c) got_c.push_back(od_c);
            if (ov_s) got_s.push_back(od_s);
            if (dn_c) begin
                pulses_c++;
                if (done_c == 0) done_c = n;
                check(busy_c == 1'b0, {name, " R8 busy low at done"}, busy_c, 0);
            end
            if (dn_s) begin
                pulses_s++;
                if (done_s == 0) done_s = n;
            end
            if (inject && n == 5) begin
                in_valid = 1'b1;
                in_data  = 8'd99;
                in_last  = 1'b1;
            end else begin
                in_valid = 1'b0;
                in_last  = 1'b0;
            end
            lim = (done_c > done_s) ? done_c : done_s;
            if (done_c != 0 && done_s != 0 && n >= lim + 3) break;
        end
        check(done_c == 256 + extra, {name, " R7 sweep length"}, done_c, 256 + extra);
        check(done_s == 256, {name, " R7 sweep length single"}, done_s, 256);
        check(pulses_c == 1, {name, " R8 done pulses"}, pulses_c, 1);
        check(pulses_s == 1, {name, " R8 done pulses single"}, pulses_s, 1);
        check(got_c.size() == exp_c.size(), {name, " R5 output count"}, got_c.size(), exp_c.size());
        for (int i = 0; i < got_c.size() && i < exp_c.size(); i++)
            check(got_c[i] == exp_c[i], {name, " R4 R5 sorted value"}, got_c[i], exp_c[i]);
        check(got_s.size() == exp_s.size(), {name, " R6 output count single"}, got_s.size(), exp_s.size());
        for (int i = 0; i < got_s.size() && i < exp_s.size(); i++)
            check(got_s[i] == exp_s[i], {name, " R6 sorted value single"}, got_s[i], exp_s[i]);
        clear_model();
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        clear_model();
        repeat (3) @(posedge clk);
        #1;
        check(busy_c == 0 && busy_s == 0, "R1 busy after reset", busy_c, 0);
        check(ov_c == 0 && ov_s == 0, "R1 out_valid after reset", ov_c, 0);
        check(dn_c == 0 && dn_s == 0, "R1 out_done after reset", dn_c, 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_distinct();   // R2 R4
        push_val(200); push_val(3); push_val(77);
        push_val(0); push_val(255); push_val(128);
        close_and_check("distinct", 1'b0, 0, 1'b0);
    endtask

    task automatic t_dups();       // R5 R6
        push_val(250); push_val(5); push_val(9); push_val(5);
        push_val(250); push_val(5);
        close_and_check("duplicates", 1'b0, 0, 1'b0);
    endtask

    task automatic t_saturate();   // R5 ceiling at 7
        for (int k = 0; k < 9; k++) push_val(42);
        push_val(255); push_val(255);
        close_and_check("saturate", 1'b0, 0, 1'b0);
    endtask

    task automatic t_empty();      // R7 empty batch
        close_and_check("empty", 1'b0, 0, 1'b0);
    endtask

    task automatic t_ignored();    // R9 then R10
        push_val(10);
        close_and_check("busy_input R9", 1'b0, 0, 1'b1);
        push_val(20);
        close_and_check("next_batch R9 R10", 1'b0, 0, 1'b0);
    endtask

    task automatic t_same_cycle(); // R11
        push_val(100);
        close_and_check("value_with_last R11", 1'b1, 7, 1'b0);
    endtask

    initial begin
        t_reset();
        t_distinct();
        t_dups();
        t_saturate();
        t_empty();
        t_ignored();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule